// File: doc/BRIEF.md
# Multi-vector predicated select unit

This block carries out a conditional select over a group of two or four vector registers in a single instruction. It accepts a 32-bit instruction word and decodes from it the element size, the base registers of three register groups and a predicate selector. It then reads both source groups from a vector register file held inside the block. The chosen predicate holds a compact counter: an element count plus an invert flag. The block expands that counter into one mask bit per element, and the mask runs across all members of the group laid end to end.

Each destination element takes the element from the first source group where its mask bit is true. Where the bit is false, it takes the matching element from the second source group. The whole group is updated on the clock edge that samples the issue strobe, so the latency is the same for every operand value.

A load port and a read port on the register file let the surrounding logic fill the vector and predicate registers and inspect the results. An encoding that is not recognised raises a one-cycle undefined flag and writes nothing. The vector length is a parameter of at least 128 bits.

Top module: `mvsel_unit`

## Requirements
- R1: The size field insn[23:22] sets the element width to 8 << size: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64.
- R2: Two-register form. The fields are insn[20:17] for the second source, insn[9:6] for the first source and insn[4:1] for the destination. Each group base is the field value times 2, and group member r is base+r for r = 0 and 1.
- R3: Four-register form. The fields are insn[20:18] for the second source, insn[9:7] for the first source and insn[4:2] for the destination. Each group base is the field value times 4, and the group is base to base+3.
- R4: The predicate register number is 8 plus the value of insn[12:10], so predicate registers 0 to 7 never take part in a select.
- R5: A word is accepted only when all of the following hold: insn[31:24] = 8'hC1, insn[21] = 1, and either insn[16:13] = 4'b0100 with insn[5] = 0 and insn[0] = 0 (two-register form), or insn[17:13] = 5'b01100 with insn[6:5] = 0 and insn[1:0] = 0 (four-register form). An issue of any other word asserts `undef` for exactly the next cycle and leaves every vector register unchanged.
- R6: Bits 15:0 of the predicate form the counter: bit 15 is the invert flag and bits 14:0 are the count. The count is clamped to T, where T = nreg × (VLEN/esize). The element at mask index i = r × (VLEN/esize) + e is true when (i < clamped count) XOR invert.
- R7: Every destination element takes the first-source element when its mask bit is true and the second-source element when it is false. All nreg destination registers are written on the edge that samples `issue`, and `done` is high for the following cycle.
- R8: All sources are read before any destination is written, so a destination group that overlaps a source group sees only the old source values.
- R9: Vector registers outside the destination group keep their contents.
- R10: The result and the `done` strobe always appear exactly one cycle after issue, whatever the data or predicate values. Without an issue, neither `done` nor `undef` is raised.
- R11: `ld_en` writes `ld_data` into vector register `ld_addr`, and `pw_en` writes `pw_data` into predicate register `pw_addr`, both on the clock edge. `rd_data` shows vector register `rd_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control flops |
| issue | input | 1 | Execute `insn` on this edge |
| insn | input | 32 | Instruction word |
| ld_en | input | 1 | Vector register load strobe |
| ld_addr | input | 5 | Vector register to load |
| ld_data | input | VLEN_BITS | Load data |
| pw_en | input | 1 | Predicate register load strobe |
| pw_addr | input | 4 | Predicate register to load |
| pw_data | input | VLEN_BITS/8 | Predicate load data |
| rd_addr | input | 5 | Vector register to observe |
| rd_data | output | VLEN_BITS | Contents of register `rd_addr` |
| done | output | 1 | An accepted select completed on the previous edge |
| undef | output | 1 | The previous issue carried an unrecognised encoding |

## Verification
The assertions assume that the load port is idle on any cycle that issues an illegal word, and that `rd_addr` stays still across such an issue; the register-unchanged property depends on both. They also assume that the instruction write and a load never aim at the same register in the same cycle. The bench honours all three assumptions, because its tasks drive each strobe on its own falling edge, one at a time, and hold `rd_addr` steady outside its read-back loops. Predicate counts are written only through the predicate load port, before the instruction that uses them is issued.

// File: rtl/mvsel_pkg.sv
package mvsel_pkg;

  localparam int unsigned INSN_W   = 32;
  localparam int unsigned VREG_AW  = 5;
  localparam int unsigned PREG_AW  = 4;
  localparam int unsigned GRP_MAX  = 4;
  localparam int unsigned CTR_W    = 16;

  localparam logic [7:0] OPC_HI   = 8'hC1;
  localparam logic [3:0] TWO_TAG  = 4'b0100;
  localparam logic [4:0] FOUR_TAG = 5'b01100;

  typedef struct packed {
    logic               legal;
    logic               four;
    logic [1:0]         sz;
    logic [PREG_AW-1:0] preg;
    logic [VREG_AW-1:0] zn_base;
    logic [VREG_AW-1:0] zm_base;
    logic [VREG_AW-1:0] zd_base;
  } mvsel_dec_t;

endpackage

// File: rtl/mvsel_decode.sv
module mvsel_decode
  import mvsel_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output mvsel_dec_t        dec
);

  logic hdr_ok;
  logic two_ok;
  logic four_ok;

  always_comb begin
    hdr_ok  = (insn[31:24] == OPC_HI) && insn[21];
    two_ok  = hdr_ok && (insn[16:13] == TWO_TAG) && !insn[5] && !insn[0];
    four_ok = hdr_ok && (insn[17:13] == FOUR_TAG) &&
              (insn[6:5] == 2'b00) && (insn[1:0] == 2'b00);

    dec       = '0;
    dec.legal = two_ok || four_ok;
    dec.four  = four_ok;
    dec.sz    = insn[23:22];
    dec.preg  = {1'b1, insn[12:10]};
    if (four_ok) begin
      dec.zm_base = {insn[20:18], 2'b00};
      dec.zn_base = {insn[9:7],   2'b00};
      dec.zd_base = {insn[4:2],   2'b00};
    end else begin
      dec.zm_base = {insn[20:17], 1'b0};
      dec.zn_base = {insn[9:6],   1'b0};
      dec.zd_base = {insn[4:1],   1'b0};
    end
  end

endmodule

// File: rtl/mvsel_mask.sv
module mvsel_mask
  import mvsel_pkg::*;
#(
  parameter int unsigned PL = 16
) (
  input  logic [CTR_W-1:0]  pctr,
  input  logic              four,
  input  logic [1:0]        sz,
  output logic [4*PL-1:0]   bmask
);

  localparam int unsigned GB = GRP_MAX * PL;

  logic [CTR_W-1:0] total;
  logic [CTR_W-1:0] cnt;
  logic [CTR_W-1:0] lim;
  logic             inv;

  always_comb begin
    total = (four ? CTR_W'(4 * PL) : CTR_W'(2 * PL)) >> sz;
    cnt   = {1'b0, pctr[CTR_W-2:0]};
    inv   = pctr[CTR_W-1];
    lim   = (cnt > total) ? total : cnt;
  end

  for (genvar g = 0; g < GB; g++) begin : g_byte
    localparam logic [CTR_W-1:0] BIDX = CTR_W'(g);
    assign bmask[g] = ((BIDX >> sz) < lim) ^ inv;
  end

endmodule

// File: rtl/mvsel_select.sv
module mvsel_select
  import mvsel_pkg::*;
#(
  parameter int unsigned VL = 128
) (
  input  logic [GRP_MAX*VL-1:0]     src_a,
  input  logic [GRP_MAX*VL-1:0]     src_b,
  input  logic [GRP_MAX*VL/8-1:0]   bmask,
  output logic [GRP_MAX*VL-1:0]     dst
);

  localparam int unsigned GB = GRP_MAX * VL / 8;

  for (genvar g = 0; g < GB; g++) begin : g_lane
    assign dst[g*8 +: 8] = bmask[g] ? src_a[g*8 +: 8] : src_b[g*8 +: 8];
  end

endmodule

// File: rtl/mvsel_regs.sv
module mvsel_regs
  import mvsel_pkg::*;
#(
  parameter int unsigned VL = 128,
  parameter int unsigned NP = 16
) (
  input  logic                   clk,
  input  logic                   ld_en,
  input  logic [VREG_AW-1:0]     ld_addr,
  input  logic [VL-1:0]          ld_data,
  input  logic                   pw_en,
  input  logic [PREG_AW-1:0]     pw_addr,
  input  logic [VL/8-1:0]        pw_data,
  input  logic                   grp_we,
  input  logic                   grp_four,
  input  logic [VREG_AW-1:0]     grp_base,
  input  logic [GRP_MAX*VL-1:0]  grp_data,
  input  logic [VREG_AW-1:0]     a_base,
  input  logic [VREG_AW-1:0]     b_base,
  output logic [GRP_MAX*VL-1:0]  src_a,
  output logic [GRP_MAX*VL-1:0]  src_b,
  input  logic [PREG_AW-1:0]     p_idx,
  output logic [CTR_W-1:0]       pctr,
  input  logic [VREG_AW-1:0]     dbg_addr,
  output logic [VL-1:0]          dbg_data
);

  localparam int unsigned NV = 1 << VREG_AW;
  localparam int unsigned PL = VL / 8;

  logic [VL-1:0] vreg   [NV];
  logic [VL-1:0] vreg_d [NV];
  logic [NV-1:0] vreg_we;
  logic [PL-1:0] preg   [NP];

  // next-state: group write wins over the load port
  always_comb begin
    logic [VREG_AW-1:0] off;
    logic               hit;
    for (int v = 0; v < NV; v++) begin
      off        = VREG_AW'(v) - grp_base;
      hit        = grp_we && (off < (grp_four ? VREG_AW'(4) : VREG_AW'(2)));
      vreg_we[v] = hit || (ld_en && (ld_addr == VREG_AW'(v)));
      vreg_d[v]  = hit ? grp_data[off[1:0]*VL +: VL] : ld_data;
    end
  end

  always_ff @(posedge clk) begin
    for (int v = 0; v < NV; v++) begin
      if (vreg_we[v]) vreg[v] <= vreg_d[v];
    end
  end

  always_ff @(posedge clk) begin
    if (pw_en) preg[pw_addr] <= pw_data;
  end

  for (genvar r = 0; r < GRP_MAX; r++) begin : g_rd
    assign src_a[r*VL +: VL] = vreg[VREG_AW'(a_base + VREG_AW'(r))];
    assign src_b[r*VL +: VL] = vreg[VREG_AW'(b_base + VREG_AW'(r))];
  end

  assign pctr     = preg[p_idx][CTR_W-1:0];
  assign dbg_data = vreg[dbg_addr];

endmodule

// File: rtl/mvsel_unit.sv
module mvsel_unit
  import mvsel_pkg::*;
#(
  parameter int unsigned VLEN_BITS = 128,
  parameter int unsigned NUM_PREGS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue,
  input  logic [31:0]            insn,
  input  logic                   ld_en,
  input  logic [4:0]             ld_addr,
  input  logic [VLEN_BITS-1:0]   ld_data,
  input  logic                   pw_en,
  input  logic [3:0]             pw_addr,
  input  logic [VLEN_BITS/8-1:0] pw_data,
  input  logic [4:0]             rd_addr,
  output logic [VLEN_BITS-1:0]   rd_data,
  output logic                   done,
  output logic                   undef
);

  localparam int unsigned PL = VLEN_BITS / 8;
  localparam int unsigned GW = GRP_MAX * VLEN_BITS;

  mvsel_dec_t        dec;
  logic              dec_legal;
  logic              exec_we;
  logic [CTR_W-1:0]  pctr;
  logic [GRP_MAX*PL-1:0] bmask;
  logic [GW-1:0]     src_a;
  logic [GW-1:0]     src_b;
  logic [GW-1:0]     dst;
  logic              done_d;
  logic              undef_d;

  mvsel_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  assign dec_legal = dec.legal;
  assign exec_we   = issue && dec_legal;

  mvsel_regs #(
    .VL (VLEN_BITS),
    .NP (NUM_PREGS)
  ) u_regs (
    .clk      (clk),
    .ld_en    (ld_en),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .pw_en    (pw_en),
    .pw_addr  (pw_addr),
    .pw_data  (pw_data),
    .grp_we   (exec_we),
    .grp_four (dec.four),
    .grp_base (dec.zd_base),
    .grp_data (dst),
    .a_base   (dec.zn_base),
    .b_base   (dec.zm_base),
    .src_a    (src_a),
    .src_b    (src_b),
    .p_idx    (dec.preg),
    .pctr     (pctr),
    .dbg_addr (rd_addr),
    .dbg_data (rd_data)
  );

  mvsel_mask #(
    .PL (PL)
  ) u_mask (
    .pctr  (pctr),
    .four  (dec.four),
    .sz    (dec.sz),
    .bmask (bmask)
  );

  mvsel_select #(
    .VL (VLEN_BITS)
  ) u_sel (
    .src_a (src_a),
    .src_b (src_b),
    .bmask (bmask),
    .dst   (dst)
  );

  always_comb begin
    done_d  = issue && dec_legal;
    undef_d = issue && !dec_legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      undef <= 1'b0;
    end else begin
      done  <= done_d;
      undef <= undef_d;
    end
  end

endmodule

// File: rtl/mvsel_unit_chk.sv
module mvsel_unit_chk #(
  parameter int unsigned VLEN_BITS = 128
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     issue,
  input logic                     dec_legal,
  input logic                     ld_en,
  input logic [4:0]               rd_addr,
  input logic [VLEN_BITS-1:0]     rd_data,
  input logic                     done,
  input logic                     undef,
  input logic [15:0]              pctr,
  input logic [VLEN_BITS/2-1:0]   bmask,
  input logic [4*VLEN_BITS-1:0]   src_a,
  input logic [4*VLEN_BITS-1:0]   dst
);

  // R5
  illegal_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !dec_legal) |=> (undef && !done));

  // R5
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !dec_legal && !ld_en) |=>
      ((rd_addr != $past(rd_addr)) || (rd_data == $past(rd_data))));

  // R7
  legal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dec_legal) |=> (done && !undef));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!done && !undef));

  // R6
  empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pctr == 16'h0000) |-> (bmask == '0));

  // R7
  all_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&bmask) |-> (dst == src_a));

endmodule

bind mvsel_unit mvsel_unit_chk #(
  .VLEN_BITS (VLEN_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .issue     (issue),
  .dec_legal (dec_legal),
  .ld_en     (ld_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .done      (done),
  .undef     (undef),
  .pctr      (pctr),
  .bmask     (bmask),
  .src_a     (src_a),
  .dst       (dst)
);

// File: tb/mvsel_unit_bench.sv
module mvsel_unit_bench;

  localparam int VL = 128;
  localparam int PL = VL / 8;
  localparam int NV = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          issue;
  logic [31:0]   insn;
  logic          ld_en;
  logic [4:0]    ld_addr;
  logic [VL-1:0] ld_data;
  logic          pw_en;
  logic [3:0]    pw_addr;
  logic [PL-1:0] pw_data;
  logic [4:0]    rd_addr;
  logic [VL-1:0] rd_data;
  logic          done;
  logic          undef;

  logic [VL-1:0] mdl   [NV];
  logic [15:0]   mpred [16];
  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  mvsel_unit #(.VLEN_BITS(VL), .NUM_PREGS(16)) u_mvsel_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .pw_en(pw_en), .pw_addr(pw_addr), .pw_data(pw_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .undef(undef)
  );

  task automatic chk_bit(string req, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
    end
  endtask

  task automatic chk_vec(string req, string what, logic [VL-1:0] act, logic [VL-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc2(int sz, int zm, int pnv, int zn, int zd);
    return {8'hC1, 2'(sz), 1'b1, 4'(zm), 4'b0100, 3'(pnv), 4'(zn), 1'b0, 4'(zd), 1'b0};
  endfunction

  function automatic logic [31:0] enc4(int sz, int zm, int pnv, int zn, int zd);
    return {8'hC1, 2'(sz), 1'b1, 3'(zm), 5'b01100, 3'(pnv), 3'(zn), 2'b00, 3'(zd), 2'b00};
  endfunction

  task automatic load_v(int a, logic [VL-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 5'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    mdl[a] = d;
  endtask

  task automatic load_p(int a, logic [15:0] v);
    @(negedge clk);
    pw_en = 1'b1; pw_addr = 4'(a); pw_data = PL'(v);
    @(negedge clk);
    pw_en = 1'b0;
    mpred[a] = v;
  endtask

  // independent model of the select, from the requirements
  task automatic model_exec(bit four, int sz, int zn, int zm, int zd, int pnv);
    logic [VL-1:0] old [NV];
    logic [15:0] pv;
    int nreg, n, m, d, cnt, lim, total, gi, el;
    bit inv, act;
    for (int a = 0; a < NV; a++) old[a] = mdl[a];
    nreg  = four ? 4 : 2;
    n     = zn * nreg;
    m     = zm * nreg;
    d     = zd * nreg;
    pv    = mpred[8 + pnv];
    cnt   = int'(pv[14:0]);
    inv   = pv[15];
    total = nreg * (PL >> sz);
    lim   = (cnt > total) ? total : cnt;
    for (int r = 0; r < nreg; r++) begin
      for (int b = 0; b < PL; b++) begin
        gi  = r * PL + b;
        el  = gi >> sz;
        act = (el < lim) ^ inv;
        mdl[d + r][b*8 +: 8] = act ? old[n + r][b*8 +: 8] : old[m + r][b*8 +: 8];
      end
    end
  endtask

  task automatic run_op(string req, logic [31:0] word, bit ok);
    @(negedge clk);
    issue = 1'b1; insn = word;
    @(negedge clk);
    issue = 1'b0;
    chk_bit({req, " R10"}, "done", done, ok);
    chk_bit({req, " R5"}, "undef", undef, !ok);
    for (int a = 0; a < NV; a++) begin
      rd_addr = 5'(a);
      #1;
      chk_vec({req, " R9"}, $sformatf("v%0d", a), rd_data, mdl[a]);
    end
    rd_addr = 5'd0;
    @(negedge clk);
    chk_bit("R10", "done after one cycle", done, 1'b0);
  endtask

  task automatic t_reset();
    chk_bit("R7", "done at reset", done, 1'b0);
    chk_bit("R5", "undef at reset", undef, 1'b0);
  endtask

  task automatic t_fill();
    logic [VL-1:0] pat;
    for (int a = 0; a < NV; a++) begin
      for (int j = 0; j < PL; j++) pat[j*8 +: 8] = 8'(a * 29 + j * 7 + 3);
      load_v(a, pat);
    end
    for (int p = 0; p < 16; p++) load_p(p, 16'(p * 3 + 1));
    rd_addr = 5'd17;
    #1;
    chk_vec("R11", "load read-back", rd_data, mdl[17]);
    rd_addr = 5'd0;
  endtask

  task automatic t_two_byte();
    load_p(9, 16'd5);
    model_exec(1'b0, 0, 2, 5, 7, 1);
    run_op("R1 R2 R6 R7", enc2(0, 5, 1, 2, 7), 1'b1);
  endtask

  task automatic t_two_half();
    load_p(10, 16'd10);
    model_exec(1'b0, 1, 3, 1, 0, 2);
    run_op("R1 R2 R6 R7", enc2(1, 1, 2, 3, 0), 1'b1);
  endtask

  task automatic t_four_word_inv();
    load_p(12, 16'h8009);
    model_exec(1'b1, 2, 2, 1, 5, 4);
    run_op("R1 R3 R6 R7", enc4(2, 1, 4, 2, 5), 1'b1);
  endtask

  task automatic t_four_dbl_clamp();
    load_p(15, 16'h7FFF);
    model_exec(1'b1, 3, 0, 3, 6, 7);
    run_op("R1 R3 R6", enc4(3, 3, 7, 0, 6), 1'b1);
    load_p(15, 16'hFFFF);
    model_exec(1'b1, 3, 3, 0, 6, 7);
    run_op("R3 R6", enc4(3, 0, 7, 3, 6), 1'b1);
  endtask

  task automatic t_overlap();
    load_p(8, 16'd20);
    model_exec(1'b0, 0, 2, 3, 2, 0);
    run_op("R8 R7", enc2(0, 3, 0, 2, 2), 1'b1);
  endtask

  task automatic t_pred_range();
    load_p(0, 16'h8000);
    load_p(8, 16'h0000);
    model_exec(1'b1, 0, 1, 4, 0, 0);
    run_op("R4", enc4(0, 4, 0, 1, 0), 1'b1);
  endtask

  task automatic t_illegal();
    logic [31:0] w;
    w = enc2(0, 1, 0, 2, 3); w[21] = 1'b0;
    run_op("R5 bit21", w, 1'b0);
    w = enc2(0, 1, 0, 2, 3); w[5] = 1'b1;
    run_op("R5 bit5", w, 1'b0);
    w = enc4(1, 1, 0, 2, 3); w[6] = 1'b1;
    run_op("R5 bit6", w, 1'b0);
    w = enc4(1, 1, 0, 2, 3); w[31:24] = 8'hC0;
    run_op("R5 opcode", w, 1'b0);
    w = enc2(2, 1, 0, 2, 3); w[16:13] = 4'b0000;
    run_op("R5 tag", w, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; issue = 1'b0; insn = '0;
    ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    pw_en = 1'b0; pw_addr = '0; pw_data = '0;
    rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_two_byte();
    t_two_half();
    t_four_word_inv();
    t_four_dbl_clamp();
    t_overlap();
    t_pred_range();
    t_illegal();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule